// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer controlled through a single 8-bit command register. Software writes command bytes to it. One byte value starts the timer and restarts its count. A two-byte key sequence stops the timer, but the second byte must arrive within a short window after the first. A one-time lock byte makes the stop sequence useless until the next reset. A write whose top bit is clear programs the timeout, which is a power of four clock periods.

The watchdog runs from reset with its longest interval selected. When the count reaches the selected interval while the timer is running, the block raises a one-clock reset request. The count then starts again from zero. A read returns the programmed interval and whether the timer is running.

Top module: `keyed_wdt`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `rd_data` reads 0x17: interval field [2:0] = 111b, running bit [4] = 1, all other bits 0. `wdt_rst` is 0.
- R2: A write of 0xA5 sets the running bit and clears the count. The next `wdt_rst` pulse is visible exactly 4^(3+N) cycles after the write edge, where N is the interval field.
- R3: While running with no writes, `wdt_rst` pulses high for exactly one cycle every 4^(3+N) cycles (64 for N=0).
- R4: A write with bit 7 = 0 loads bits [2:0] of the data into the interval field, which is visible on the next read. A write with bit 7 = 1 leaves the interval unchanged.
- R5: A write of 0xDE followed by a write of 0xAD at most 4 clock edges later clears the running bit. This holds only when no lock is set.
- R6: A 0xAD write has no effect in each of these cases: it arrives more than 4 edges after 0xDE, no 0xDE precedes it, or another write falls between the two.
- R7: A write of 0xFF makes every later stop sequence ignored until reset. The 0xFF write itself neither starts the timer nor clears the count.
- R8: Changing the interval while running does not clear the count. If the count is already at or beyond the new limit, the pulse comes on the next cycle.
- R9: While the running bit is 0, `wdt_rst` stays low.
- R10: Bits [7:5] and [3] of `rd_data` always read 0. Bit [4] is the running bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe, one byte per cycle |
| wr_data | input | 8 | Command byte |
| rd_data | output | 8 | Interval in [2:0], running status in [4] |
| wdt_rst | output | 1 | One-cycle timeout reset request |

## Verification
The assertions assume that every cycle with `wr_en` high carries one complete command byte, and that `wr_data` is only meaningful in those cycles. They also assume the interval stays at a value whose period is far longer than one cycle, so that two pulses can never be adjacent. The stimulus drives the strobe and the byte together on the falling edge and holds them for a whole cycle. It keeps the interval at N of 0 to 2 so that every timeout and window boundary falls within a short run.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int BASE_EXP = 3,
  parameter int WIN      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       wdt_rst
);
  localparam int CW = 2 * (BASE_EXP + 7);
  localparam int AW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [7:0] K_KICK = 8'hA5;
  localparam logic [7:0] K_ARM  = 8'hDE;
  localparam logic [7:0] K_STOP = 8'hAD;
  localparam logic [7:0] K_LOCK = 8'hFF;
  localparam logic [CW:0] ONE   = (CW+1)'(1);

  logic          active, locked, armed;
  logic [2:0]    ival;
  logic [AW-1:0] age;
  logic [CW-1:0] cnt;
  logic [CW:0]   lim;

  assign lim = ONE << (2 * (BASE_EXP + int'(ival)));

  wire kick = wr_en && (wr_data == K_KICK);
  wire stop = wr_en && (wr_data == K_STOP) && armed && !locked;
  wire due  = active && !kick && !stop && ({1'b0, cnt} >= (lim - ONE));

  assign rd_data = {3'b000, active, 1'b0, ival};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b1;
      locked  <= 1'b0;
      armed   <= 1'b0;
      age     <= '0;
      ival    <= 3'b111;
      cnt     <= '0;
      wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= due;

      if (kick)      active <= 1'b1;
      else if (stop) active <= 1'b0;

      if (kick || stop || !active || due) cnt <= '0;
      else                                cnt <= cnt + CW'(1);

      if (wr_en && (wr_data == K_LOCK)) locked <= 1'b1;
      if (wr_en && !wr_data[7])         ival   <= wr_data[2:0];

      if (wr_en) begin
        armed <= (wr_data == K_ARM);
        age   <= '0;
      end else if (armed) begin
        if (age == AW'(WIN - 1)) armed <= 1'b0;
        else                     age   <= age + AW'(1);
      end
    end
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       wdt_rst
);
  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  // R9
  pulse_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[4] |=> !wdt_rst);

  // R2
  kick_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 8'hA5) |=> (rd_data[4] && !wdt_rst));

  // R4
  ival_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7]) |=> (rd_data[2:0] == $past(wr_data[2:0])));

  // R4
  ival_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_data[7]) |=> $stable(rd_data[2:0]));

  // R5
  stop_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[4]) |-> $past(wr_en && wr_data == 8'hAD));

  // R10
  read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:5] == 3'b000) && !rd_data[3]);
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .wdt_rst(wdt_rst)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       wdt_rst;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  keyed_wdt u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                   .rd_data(rd_data), .wdt_rst(wdt_rst));

  always #10 clk = ~clk;

  // behavioural reference
  bit m_act, m_lock, m_arm, m_rst;
  int m_iv, m_cnt, m_since;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 1; m_lock = 0; m_arm = 0; m_rst = 0;
      m_iv = 7; m_cnt = 0; m_since = 0;
    end else begin
      bit kick, stop, due;
      int lim;
      lim  = 1 << (2 * (3 + m_iv));
      kick = wr_en && wr_data == 8'hA5;
      stop = wr_en && wr_data == 8'hAD && m_arm && m_since <= 3 && !m_lock;
      due  = m_act && !kick && !stop && (m_cnt + 1 >= lim);
      m_rst = due;
      if (kick) begin m_act = 1; m_cnt = 0; end
      else if (stop) begin m_act = 0; m_cnt = 0; end
      else if (!m_act || due) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      if (wr_en && wr_data == 8'hFF) m_lock = 1;
      if (wr_en && !wr_data[7]) m_iv = int'(wr_data[2:0]);
      if (wr_en) begin m_arm = (wr_data == 8'hDE); m_since = 0; end
      else if (m_arm) begin
        if (m_since >= 3) m_arm = 0; else m_since = m_since + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 model rd_data", int'(rd_data), int'({3'b000, m_act, 1'b0, 3'(m_iv)}));
      chk("R9 model wdt_rst", int'(wdt_rst), int'(m_rst));
    end
  end

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    chk("R1 reset rd_data", int'(rd_data), 'h17);
    chk("R1 reset wdt_rst", int'(wdt_rst), 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 after release", int'(rd_data), 'h17);

    wr(8'h00);
    chk("R4 interval load", int'(rd_data[2:0]), 0);
    wr(8'hA5);
    idle(63);
    chk("R2 no pulse before limit", int'(wdt_rst), 0);
    idle(1);
    chk("R2 pulse at 64", int'(wdt_rst), 1);
    idle(1);
    chk("R3 single cycle pulse", int'(wdt_rst), 0);
    idle(62);
    chk("R3 quiet before period", int'(wdt_rst), 0);
    idle(1);
    chk("R3 second pulse at 128", int'(wdt_rst), 1);

    wr(8'h81);
    chk("R4 bit7 set keeps interval", int'(rd_data[2:0]), 0);

    wr(8'hDE); idle(4); wr(8'hAD);
    chk("R6 late stop ignored", int'(rd_data[4]), 1);
    wr(8'hAD);
    chk("R6 unarmed stop ignored", int'(rd_data[4]), 1);
    wr(8'hDE); wr(8'h01); wr(8'hAD);
    chk("R6 intervening write cancels", int'(rd_data[4]), 1);
    wr(8'h00);

    wr(8'hA5); wr(8'hDE); idle(3); wr(8'hAD);
    chk("R5 on-time stop", int'(rd_data[4]), 0);
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (wdt_rst) seen = 1'b1;
    end
    chk("R9 no pulse while stopped", int'(seen), 0);
    wr(8'hFF);
    chk("R7 lock does not start", int'(rd_data[4]), 0);
    chk("R10 read format", int'(rd_data), 'h00);

    wr(8'hA5);
    chk("R2 restart after stop", int'(rd_data[4]), 1);
    wr(8'hDE); wr(8'hAD);
    chk("R7 stop ignored when locked", int'(rd_data[4]), 1);

    wr(8'hA5); idle(10); wr(8'hFF);
    idle(52);
    chk("R7 lock byte keeps count", int'(wdt_rst), 0);
    idle(1);
    chk("R7 pulse unaffected by lock byte", int'(wdt_rst), 1);

    wr(8'h02); wr(8'hA5); idle(20); wr(8'h00);
    idle(42);
    chk("R8 count kept across change", int'(wdt_rst), 0);
    idle(1);
    chk("R8 pulse at new limit", int'(wdt_rst), 1);

    wr(8'h02); wr(8'hA5); idle(200); wr(8'h00);
    chk("R8 no pulse on change edge", int'(wdt_rst), 0);
    idle(1);
    chk("R8 overshoot fires next cycle", int'(wdt_rst), 1);

    rst_n = 1'b0;
    idle(2);
    chk("R1 second reset", int'(rd_data), 'h17);
    rst_n = 1'b1;
    idle(1);
    wr(8'h00); wr(8'hDE); wr(8'hAD);
    chk("R7 lock cleared by reset", int'(rd_data[4]), 0);
    idle(5);
    finish_run();
  end
endmodule